// File: doc/BRIEF.md
# Stereo Serial Audio Transmitter

This block turns pairs of stereo samples into a serial bit stream with a selectable framing format. Sample pairs come in through a valid/ready handshake and wait in a small pair buffer. The surrounding logic generates the clocks. It marks each bit period with a one-cycle `bit_tick` strobe and the first bit of every frame with `frame_start`. On each tick the block drives the next bit on `sd_out`, most significant bit first.

Each frame holds two channel slots of `SLOT_W` bits each. A sample occupies 16, 24 or 32 bits of its slot. Samples arrive as 32-bit words aligned to the top, and shorter lengths use only their upper bits. Any slot bit that carries no sample bit is sent as zero. Three format controls are sampled at every frame start:

- A right-align bit moves the sample to the end of its slot.
- A delay bit holds the data back by one bit period, which gives the standard one-bit-delayed framing.
- A swap bit selects which channel goes first.

If the buffer is empty when a frame begins, the block sends silence and sets a sticky underrun flag.

Top module: `stereo_serial_tx`

## Requirements
- R1: After reset `sd_out` and `underrun` are 0. With `tx_en` low, `smp_ready` is 0.
- R2: A pair is taken when `smp_valid` and `smp_ready` are both high on a clock edge. `smp_ready` is high only while `tx_en` is set and the buffer holds fewer than `FIFO_DEPTH` pairs (default 4). One pair is removed at each enabled frame start.
- R3: `word_len` code 0 selects 16 bits, code 1 selects 24 bits, and codes 2 and 3 select 32 bits. Only the top bits of each 32-bit sample are used, and the lower bits are not sent.
- R4: On a clock edge with `bit_tick` high, `sd_out` takes the next bit, most significant first. A tick that also has `frame_start` high begins a new frame of 2*`SLOT_W` ticks (64 by default), and the first slot fills the first half of the frame.
- R5: With `right_align` = 0, the sample MSB is slot position 0 and every later slot bit beyond the sample is 0.
- R6: With `right_align` = 1, the sample LSB is the last slot position and the leading slot bits are 0.
- R7: With `first_bit_delay` = 1, every bit is sent one tick later. Frame position 0 then carries the last bit of the previous frame. That bit is 0 if the previous frame was undelayed, was silent, or does not exist.
- R8: With `swap_order` = 0 the left sample fills the first slot. With `swap_order` = 1 the right sample fills the first slot.
- R9: A frame start with an empty buffer sends an all-zero frame and sets `underrun`. `underrun` stays set until a cycle with `underrun_clr` = 1, and a new underrun in that same cycle wins over the clear.
- R10: While `tx_en` is low the buffer is emptied, `sd_out` stays 0, the pending delayed bit is dropped, and frame starts cause no underrun.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| tx_en | input | 1 | Transmit enable |
| bit_tick | input | 1 | One-cycle strobe for each bit period |
| frame_start | input | 1 | Marks the first bit of a frame (qualified by bit_tick) |
| word_len | input | 2 | Sample length code: 0=16, 1=24, 2/3=32 |
| right_align | input | 1 | Put the sample at the end of its slot |
| first_bit_delay | input | 1 | Delay data by one bit after the frame start |
| swap_order | input | 1 | Send the right channel in the first slot |
| smp_valid | input | 1 | Sample pair valid |
| smp_ready | output | 1 | Buffer can accept a pair |
| smp_left | input | 32 | Left sample, aligned to the top |
| smp_right | input | 32 | Right sample, aligned to the top |
| underrun | output | 1 | Sticky flag: a frame started with no data |
| underrun_clr | input | 1 | Clears underrun when high |
| sd_out | output | 1 | Serial data |

## Verification
`sd_out` changes on the same clock edge that samples `bit_tick`. The monitor records every ticked edge and reads `sd_out` at the following falling edge, one register stage later. `underrun` is set on the edge of the frame-start tick and is read only after that frame has finished. `smp_ready` depends on the buffer count and on `tx_en`, so the bench reads it on the falling edge after a push, a pop or an enable change. The expected bit stream for each frame is queued before the frame is played, including the bit carried over from the previous frame.

// File: rtl/stx_pkg.sv
package stx_pkg;

    localparam int SAMPLE_W = 32;

    typedef enum logic [1:0] {
        WL_16  = 2'd0,
        WL_24  = 2'd1,
        WL_32  = 2'd2,
        WL_32B = 2'd3
    } wlen_e;

    typedef struct packed {
        logic [SAMPLE_W-1:0] left;
        logic [SAMPLE_W-1:0] right;
    } pair_t;

    typedef struct packed {
        wlen_e wlen;
        logic  right_align;
        logic  bit_delay;
        logic  swap;
    } fmt_t;

    function automatic int unsigned word_bits(wlen_e w);
        case (w)
            WL_16:   return 16;
            WL_24:   return 24;
            default: return 32;
        endcase
    endfunction

    // ones over the bits that carry sample data
    function automatic logic [SAMPLE_W-1:0] keep_mask(wlen_e w);
        return ~({SAMPLE_W{1'b1}} >> word_bits(w));
    endfunction

endpackage

// File: rtl/stx_pair_fifo.sv
module stx_pair_fifo
    import stx_pkg::*;
#(
    parameter int DEPTH = 4
) (
    input  logic  clk,
    input  logic  rst,
    input  logic  flush,
    input  logic  push,
    input  logic  pop,
    input  pair_t wr_data,
    output pair_t rd_data,
    output logic  full,
    output logic  empty
);

    localparam int AW = (DEPTH > 1) ? $clog2(DEPTH) : 1;
    localparam int CW = $clog2(DEPTH + 1);
    localparam logic [AW-1:0] LAST = AW'(DEPTH - 1);
    localparam logic [CW-1:0] FULL_CNT = CW'(DEPTH);

    pair_t          store [DEPTH];
    logic [AW-1:0]  wptr, rptr;
    logic [CW-1:0]  cnt;
    logic           do_push, do_pop;

    assign full    = (cnt == FULL_CNT);
    assign empty   = (cnt == '0);
    assign do_push = push && !full && !flush;
    assign do_pop  = pop && !empty;
    assign rd_data = store[rptr];

    always_ff @(posedge clk) begin
        if (do_push) store[wptr] <= wr_data;
    end

    always_ff @(posedge clk) begin
        if (rst || flush) begin
            wptr <= '0;
            rptr <= '0;
            cnt  <= '0;
        end else begin
            if (do_push) wptr <= (wptr == LAST) ? '0 : wptr + 1'b1;
            if (do_pop)  rptr <= (rptr == LAST) ? '0 : rptr + 1'b1;
            if (do_push && !do_pop)      cnt <= cnt + 1'b1;
            else if (do_pop && !do_push) cnt <= cnt - 1'b1;
        end
    end

    // R2
    cnt_bound_chk: assert property (@(posedge clk) disable iff (rst)
        cnt <= FULL_CNT);

    // R10
    flush_empty_chk: assert property (@(posedge clk) disable iff (rst)
        flush |=> empty);

    // R2
    pop_only_stored_chk: assert property (@(posedge clk) disable iff (rst)
        (empty && !push) |=> empty);

endmodule

// File: rtl/stx_slot_formatter.sv
module stx_slot_formatter
    import stx_pkg::*;
#(
    parameter int SLOT_W = 32
) (
    input  pair_t                  pair,
    input  fmt_t                   fmt,
    output logic [2*SLOT_W-1:0]    frame_vec
);

    pair_t               ordered;
    logic [SLOT_W-1:0]   slots [2];

    function automatic logic [SLOT_W-1:0] build(logic [SAMPLE_W-1:0] s,
                                                 wlen_e w, logic ra);
        logic [SAMPLE_W-1:0]        m;
        logic [SLOT_W+SAMPLE_W-1:0] wide;
        logic [SLOT_W-1:0]          r;
        m    = s & keep_mask(w);
        r    = '0;
        wide = {m, {SLOT_W{1'b0}}};
        if (ra) r[SAMPLE_W-1:0] = m >> (SAMPLE_W - word_bits(w));
        else    r = wide[SLOT_W+SAMPLE_W-1 -: SLOT_W];
        return r;
    endfunction

    always_comb begin
        if (fmt.swap) begin
            ordered.left  = pair.right;
            ordered.right = pair.left;
        end else begin
            ordered = pair;
        end
    end

    for (genvar ch = 0; ch < 2; ch++) begin : g_slot
        always_comb begin
            slots[ch] = build((ch == 0) ? ordered.left : ordered.right,
                              fmt.wlen, fmt.right_align);
        end
    end

    assign frame_vec = {slots[0], slots[1]};

endmodule

// File: rtl/stx_bit_shifter.sv
module stx_bit_shifter #(
    parameter int FRAME_W = 64
) (
    input  logic               clk,
    input  logic               rst,
    input  logic               en,
    input  logic               tick,
    input  logic               fstart,
    input  logic               delay,
    input  logic [FRAME_W-1:0] load_vec,
    output logic               sd
);

    logic [FRAME_W-1:0] sh;

    always_ff @(posedge clk) begin
        if (rst || !en) begin
            sh <= '0;
            sd <= 1'b0;
        end else if (tick) begin
            if (fstart && delay) begin
                sd <= sh[FRAME_W-1];
                sh <= load_vec;
            end else if (fstart) begin
                sd <= load_vec[FRAME_W-1];
                sh <= load_vec << 1;
            end else begin
                sd <= sh[FRAME_W-1];
                sh <= sh << 1;
            end
        end
    end

    // R10
    quiet_off_chk: assert property (@(posedge clk) disable iff (rst)
        !en |=> !sd);

    // R4
    hold_between_ticks_chk: assert property (@(posedge clk) disable iff (rst)
        (en && $past(en) && !tick) |=> $stable(sd));

endmodule

// File: rtl/stereo_serial_tx.sv
module stereo_serial_tx
    import stx_pkg::*;
#(
    parameter int SLOT_W     = 32,
    parameter int FIFO_DEPTH = 4
) (
    input  logic        clk,
    input  logic        rst,
    input  logic        tx_en,
    input  logic        bit_tick,
    input  logic        frame_start,
    input  logic [1:0]  word_len,
    input  logic        right_align,
    input  logic        first_bit_delay,
    input  logic        swap_order,
    input  logic        smp_valid,
    output logic        smp_ready,
    input  logic [31:0] smp_left,
    input  logic [31:0] smp_right,
    output logic        underrun,
    input  logic        underrun_clr,
    output logic        sd_out
);

    localparam int FRAME_W = 2 * SLOT_W;

    fmt_t               fmt;
    pair_t              in_pair, head, chosen;
    logic               full, empty, frame_go, starve;
    logic [FRAME_W-1:0] frame_vec;

    assign fmt.wlen        = wlen_e'(word_len);
    assign fmt.right_align = right_align;
    assign fmt.bit_delay   = first_bit_delay;
    assign fmt.swap        = swap_order;

    assign in_pair.left  = smp_left;
    assign in_pair.right = smp_right;

    assign smp_ready = tx_en && !full;
    assign frame_go  = tx_en && bit_tick && frame_start;
    assign starve    = frame_go && empty;
    assign chosen    = empty ? '0 : head;

    stx_pair_fifo #(.DEPTH(FIFO_DEPTH)) u_fifo (
        .clk     (clk),
        .rst     (rst),
        .flush   (!tx_en),
        .push    (smp_valid && smp_ready),
        .pop     (frame_go),
        .wr_data (in_pair),
        .rd_data (head),
        .full    (full),
        .empty   (empty)
    );

    stx_slot_formatter #(.SLOT_W(SLOT_W)) u_fmt (
        .pair      (chosen),
        .fmt       (fmt),
        .frame_vec (frame_vec)
    );

    stx_bit_shifter #(.FRAME_W(FRAME_W)) u_shift (
        .clk      (clk),
        .rst      (rst),
        .en       (tx_en),
        .tick     (bit_tick),
        .fstart   (frame_start),
        .delay    (first_bit_delay),
        .load_vec (frame_vec),
        .sd       (sd_out)
    );

    always_ff @(posedge clk) begin
        if (rst)               underrun <= 1'b0;
        else if (starve)       underrun <= 1'b1;
        else if (underrun_clr) underrun <= 1'b0;
    end

    // R9
    underrun_sticky_chk: assert property (@(posedge clk) disable iff (rst)
        (underrun && !underrun_clr) |=> underrun);

    // R9
    underrun_cause_chk: assert property (@(posedge clk) disable iff (rst)
        $rose(underrun) |-> $past(tx_en && bit_tick && frame_start));

endmodule

// File: tb/test_stereo_serial_tx.sv
module test_stereo_serial_tx;

    logic        clk = 0, rst = 1, tx_en = 0, bit_tick = 0, frame_start = 0;
    logic [1:0]  word_len = 2;
    logic        right_align = 0, first_bit_delay = 1, swap_order = 0;
    logic        smp_valid = 0, underrun_clr = 0;
    logic [31:0] smp_left = 0, smp_right = 0;
    logic        smp_ready, underrun, sd_out;

    int checks = 0, errors = 0;
    bit exp_q[$];
    string tag_q[$];
    logic tick_seen = 0;
    bit carry = 0;

    always #10 clk = ~clk;

    stereo_serial_tx i_stereo_serial_tx (
        .clk(clk), .rst(rst), .tx_en(tx_en), .bit_tick(bit_tick),
        .frame_start(frame_start), .word_len(word_len),
        .right_align(right_align), .first_bit_delay(first_bit_delay),
        .swap_order(swap_order), .smp_valid(smp_valid), .smp_ready(smp_ready),
        .smp_left(smp_left), .smp_right(smp_right), .underrun(underrun),
        .underrun_clr(underrun_clr), .sd_out(sd_out)
    );

    task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual %0h expected %0h", req, act, exp);
        end
    endtask

    // monitor: one result per ticked edge, read at the next falling edge
    always @(posedge clk) tick_seen <= bit_tick;
    always @(negedge clk) begin
        if (tick_seen) begin
            if (exp_q.size() == 0) chk("R4 (no expectation)", 32'(sd_out), 32'hx);
            else chk(tag_q.pop_front(), 32'(sd_out), 32'(exp_q.pop_front()));
        end
    end

    function automatic logic [31:0] bslot(logic [31:0] s, int wl, bit ra);
        int w;
        logic [31:0] m;
        w = (wl == 0) ? 16 : (wl == 1) ? 24 : 32;
        m = s & (32'hFFFF_FFFF << (32 - w));
        return ra ? (m >> (32 - w)) : m;
    endfunction

    task automatic expect_frame(logic [31:0] l, logic [31:0] r, bit silent,
                                bit zero_all, string tag);
        logic [63:0] v;
        logic [31:0] a, b;
        a = bslot(l, word_len, right_align);
        b = bslot(r, word_len, right_align);
        v = silent ? 64'd0 : (swap_order ? {b, a} : {a, b});
        for (int p = 0; p < 64; p++) begin
            bit e;
            if (zero_all) e = 0;
            else if (first_bit_delay) e = (p == 0) ? carry : v[64 - p];
            else e = v[63 - p];
            exp_q.push_back(e);
            tag_q.push_back(tag);
        end
        carry = (zero_all || !first_bit_delay) ? 1'b0 : v[0];
    endtask

    task automatic play_frame();
        for (int p = 0; p < 64; p++) begin
            @(negedge clk);
            bit_tick = 1; frame_start = (p == 0);
            @(negedge clk);
            bit_tick = 0; frame_start = 0;
        end
        @(negedge clk);
    endtask

    task automatic push_pair(logic [31:0] l, logic [31:0] r);
        @(negedge clk);
        smp_valid = 1; smp_left = l; smp_right = r;
        @(negedge clk);
        smp_valid = 0;
    endtask

    task automatic finish_run();
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    endtask

    initial begin
        #(20 * 200000);
        errors++;
        $display("FAIL watchdog: actual hung expected done");
        finish_run();
    end

    initial begin
        repeat (3) @(negedge clk);
        rst = 0;
        @(negedge clk);
        chk("R1 sd_out", 32'(sd_out), 0);
        chk("R1 underrun", 32'(underrun), 0);
        chk("R1 ready off", 32'(smp_ready), 0);
        tx_en = 1;
        @(negedge clk);
        chk("R2 ready on", 32'(smp_ready), 1);

        // standard framing, 32 bits, no carry yet
        push_pair(32'h8123_4567, 32'h5A5A_00FF);
        expect_frame(32'h8123_4567, 32'h5A5A_00FF, 0, 0, "R7 std frame");
        play_frame();
        // second standard frame: position 0 carries previous LSB
        push_pair(32'hC3C3_3C3D, 32'h0F0F_F0F1);
        expect_frame(32'hC3C3_3C3D, 32'h0F0F_F0F1, 0, 0, "R7 carry");
        play_frame();

        // left aligned 16-bit, swapped channels
        word_len = 0; first_bit_delay = 0; right_align = 0; swap_order = 1;
        push_pair(32'hABCD_1234, 32'h1357_9BDF);
        expect_frame(32'hABCD_1234, 32'h1357_9BDF, 0, 0, "R3 R5 R8 lj16");
        play_frame();

        // right aligned 24-bit
        word_len = 1; right_align = 1; swap_order = 0;
        push_pair(32'hFEDC_BA98, 32'h7654_3210);
        expect_frame(32'hFEDC_BA98, 32'h7654_3210, 0, 0, "R3 R6 rj24");
        play_frame();

        // standard 24-bit right after an undelayed frame
        word_len = 1; right_align = 0; first_bit_delay = 1;
        push_pair(32'h9999_99FF, 32'h8000_01FF);
        expect_frame(32'h9999_99FF, 32'h8000_01FF, 0, 0, "R7 R3 std24");
        play_frame();
        chk("R9 no underrun yet", 32'(underrun), 0);

        // underrun: empty buffer
        expect_frame(0, 0, 1, 0, "R9 silent frame");
        play_frame();
        chk("R9 underrun set", 32'(underrun), 1);
        repeat (5) @(negedge clk);
        chk("R9 sticky", 32'(underrun), 1);
        underrun_clr = 1;
        @(negedge clk);
        underrun_clr = 0;
        chk("R9 cleared", 32'(underrun), 0);

        // fill buffer
        word_len = 2;
        push_pair(32'h1111_2222, 32'h3333_4444);
        push_pair(32'h5555_6666, 32'h7777_8888);
        push_pair(32'h9999_AAAA, 32'hBBBB_CCCC);
        chk("R2 ready before full", 32'(smp_ready), 1);
        push_pair(32'hDDDD_EEEE, 32'hFFFF_0001);
        chk("R2 ready low when full", 32'(smp_ready), 0);
        expect_frame(32'h1111_2222, 32'h3333_4444, 0, 0, "R2 fifo order");
        play_frame();
        chk("R2 ready after pop", 32'(smp_ready), 1);

        // disable: flush, quiet line, no underrun
        tx_en = 0;
        @(negedge clk);
        chk("R10 ready off", 32'(smp_ready), 0);
        expect_frame(0, 0, 1, 1, "R10 quiet line");
        play_frame();
        chk("R10 no underrun", 32'(underrun), 0);
        tx_en = 1;
        @(negedge clk);
        chk("R10 ready after flush", 32'(smp_ready), 1);
        expect_frame(0, 0, 1, 0, "R10 flushed buffer");
        play_frame();
        chk("R10 empty after flush", 32'(underrun), 1);

        chk("R4 all bits consumed", 32'(exp_q.size()), 0);
        finish_run();
    end

endmodule